// File: doc/BRIEF.md
# I2C Controller Register and Event Logic

This block is the register-side half of a byte-oriented I2C controller that can act as master or slave. A bit-level engine (not part of this block) drives SCL and SDA, divides the clock and compares addresses. It reports what happens on the wire as single-cycle event pulses and level inputs. This block turns those reports into an 8-bit status view. It holds the control settings and drives four things back out: an interrupt line, a pair of DMA request lines, a repeated-START request to the engine and the acknowledge level the engine places on SDA in the ninth clock.

Software reaches two registers over a plain one-cycle write port. `reg_sel` = 0 picks control and 1 picks status, and the read data is combinational from the selected register. The control register is laid out as: bit 7 enable, bit 6 interrupt enable, bit 5 master, bit 4 transmit direction, bit 3 no-acknowledge, bit 2 repeat-start (write-only strobe), bit 1 spare storage with no effect, bit 0 DMA enable. The status bits keep their fixed order from bit 0 upward: transfer-complete, addressed-as-slave, bus-busy, arbitration-lost, reserved 0, slave read/write, interrupt flag, received-acknowledge. There is no streaming data path, so every pin is a plain control or status level; events are one-cycle pulses with no back-pressure.

Top module: `i2c_ctrl_status`

## Requirements
- R1: After reset, status reads 0x01 (only transfer-complete set), control reads 0x00, and `irq`, `dma_tx_req`, `dma_rx_req` and `rsta_pulse` are 0.
- R2: `sda_ack` is 0 in an address acknowledge cycle (`ack_cyc_addr`=1) while enabled (control bit 7), whatever bit 3 holds, and 1 there when disabled. In a data acknowledge cycle it equals control bit 3. Outside both it is 1.
- R3: A control write with bit 2 set raises `rsta_pulse` for one cycle on the next cycle only if control bit 5 (master) was set and status bus-busy was 1 before the write. Control bit 2 always reads 0.
- R4: Status bit 3 (arbitration-lost) is set the cycle after `ev_arb_lost`, or after a repeat-start write made while bus-busy is 1 and master is 0. That write gives no `rsta_pulse`.
- R5: Status bit 0 clears the cycle after `ev_xfer_start` and sets the cycle after `ev_xfer_done`. On done, status bit 7 takes `ack_in`. Done wins over start.
- R6: Status bit 2 follows `bus_busy` one cycle late. Status bit 1 sets the cycle after `ev_addr_match`, and bit 5 then takes `addr_rw`. Bit 1 clears the cycle after bus-busy falls, unless a match arrives in that cycle.
- R7: Writing the status register clears bit 6 and/or bit 3 where the written data has a 1. It changes no other status bit. A set event in the same cycle wins over the clear.
- R8: Status bit 6 (interrupt flag) sets the cycle after `ev_xfer_done`, `ev_addr_match`, `ev_arb_lost` or a lost repeat-start. `ev_xfer_done` does not set it while DMA enable and master are both 1.
- R9: `irq` equals status bit 6 AND control bit 6.
- R10: A byte-pending flag sets on `ev_xfer_done` and clears on `ev_data_access`, with set winning. `dma_tx_req` = enable AND DMA-enable AND master AND pending AND control bit 4. `dma_rx_req` is the same with control bit 4 clear. With master 0 both stay low.
- R11: Control bit 4 reads as 1 while `addr_phase` is 1, whatever was written there.
- R12: Status bit 4 always reads 0. Control bit 1 reads back as written and has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| bus_busy | input | 1 | Engine sees the bus busy |
| addr_phase | input | 1 | Engine is in an address byte |
| ev_xfer_start | input | 1 | Byte transfer begins (pulse) |
| ev_xfer_done | input | 1 | Byte transfer ends (pulse) |
| ack_in | input | 1 | Acknowledge level seen with done |
| ev_addr_match | input | 1 | Addressed as slave (pulse) |
| addr_rw | input | 1 | Read/write bit of matched address |
| ev_arb_lost | input | 1 | Arbitration lost (pulse) |
| ev_data_access | input | 1 | Data register was read or written (pulse) |
| ack_cyc_addr | input | 1 | Engine in ninth clock of an address byte |
| ack_cyc_data | input | 1 | Engine in ninth clock of a received data byte |
| sda_ack | output | 1 | Acknowledge level to drive on SDA |
| rsta_pulse | output | 1 | Repeated-START request to engine |
| irq | output | 1 | Interrupt |
| dma_tx_req | output | 1 | DMA write-data request |
| dma_rx_req | output | 1 | DMA read-data request |

## Verification
The bench targets a repeat-start written while another master holds the bus. A design that forwards it would pulse `rsta_pulse` and leave arbitration-lost clear. It also targets a byte completing in DMA master mode. There, a wrong design raises `irq` or fails to drop the request after the data access. Address acknowledge with no-acknowledge set is probed, where a faulty block would NAK its own address. Same-cycle write-one-to-clear against a set event is probed too, where a faulty block would lose an interrupt. Long random runs then compare every output against the behavioural model on every clock.

// File: rtl/i2c_cs_pkg.sv
package i2c_cs_pkg;
  localparam int REG_W = 8;
  // control field positions
  localparam int C_EN = 7, C_IE = 6, C_MST = 5, C_TX = 4, C_NOACK = 3, C_RSTA = 2, C_SPARE = 1, C_DMA = 0;
  // status field positions (fixed order)
  localparam int S_TCF = 0, S_AAS = 1, S_BUSY = 2, S_AL = 3, S_RSV = 4, S_SRW = 5, S_IF = 6, S_RXAK = 7;

  typedef struct packed {
    logic en;
    logic ie;
    logic master;
    logic tx;
    logic noack;
    logic spare;
    logic dmaen;
  } ctrl_t;

  typedef struct packed {
    logic rxak;
    logic iflag;
    logic srw;
    logic al;
    logic busy;
    logic aas;
    logic tcf;
  } stat_t;
endpackage

// File: rtl/i2c_cs_ctrl.sv
module i2c_cs_ctrl
  import i2c_cs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ctrl,
  input  ctrl_t wr_fields,
  input  logic  wr_rsta,
  input  logic  busy_q,
  output ctrl_t ctrl,
  output logic  rsta_pulse,
  output logic  rsta_loss
);
  logic rsta_ok;

  assign rsta_ok   = wr_ctrl && wr_rsta && busy_q && ctrl.master;
  assign rsta_loss = wr_ctrl && wr_rsta && busy_q && !ctrl.master;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl       <= '0;
      rsta_pulse <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= wr_fields;
      rsta_pulse <= rsta_ok;
    end
  end

  // R3: a request only follows a master that held a busy bus
  p_rsta_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsta_pulse |-> ($past(ctrl.master) && $past(busy_q)));
endmodule

// File: rtl/i2c_cs_status.sv
module i2c_cs_status
  import i2c_cs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bus_busy,
  input  logic  ev_xfer_start,
  input  logic  ev_xfer_done,
  input  logic  ack_in,
  input  logic  ev_addr_match,
  input  logic  addr_rw,
  input  logic  ev_arb_lost,
  input  logic  ev_data_access,
  input  logic  rsta_loss,
  input  logic  dma_mode,
  input  logic  clr_if,
  input  logic  clr_al,
  output stat_t st,
  output logic  pending
);
  logic if_set, al_set, busy_fall;

  assign al_set    = ev_arb_lost || rsta_loss;
  assign if_set    = (ev_xfer_done && !dma_mode) || ev_addr_match || al_set;
  assign busy_fall = st.busy && !bus_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= '0;
      st.tcf  <= 1'b1;
      pending <= 1'b0;
    end else begin
      st.busy <= bus_busy;
      if (ev_xfer_done) begin
        st.tcf  <= 1'b1;
        st.rxak <= ack_in;
      end else if (ev_xfer_start) begin
        st.tcf <= 1'b0;
      end
      if (ev_addr_match) begin
        st.aas <= 1'b1;
        st.srw <= addr_rw;
      end else if (busy_fall) begin
        st.aas <= 1'b0;
      end
      if (al_set)      st.al <= 1'b1;
      else if (clr_al) st.al <= 1'b0;
      if (if_set)      st.iflag <= 1'b1;
      else if (clr_if) st.iflag <= 1'b0;
      if (ev_xfer_done)        pending <= 1'b1;
      else if (ev_data_access) pending <= 1'b0;
    end
  end

  p_tcf_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer_done |=> st.tcf);
  p_al_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_arb_lost || rsta_loss) |=> st.al);
  p_aas_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_match |=> st.aas);
  p_iflag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st.iflag && !clr_if) |=> st.iflag);
  p_dma_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!st.iflag && dma_mode && !ev_addr_match && !ev_arb_lost && !rsta_loss) |=> !st.iflag);
endmodule

// File: rtl/i2c_cs_out.sv
module i2c_cs_out
  import i2c_cs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  input  logic  iflag,
  input  logic  pending,
  input  logic  ack_cyc_addr,
  input  logic  ack_cyc_data,
  output logic  sda_ack,
  output logic  irq,
  output logic  dma_tx_req,
  output logic  dma_rx_req
);
  logic dma_go;

  assign dma_go     = ctrl.en && ctrl.dmaen && ctrl.master && pending;
  assign dma_tx_req = dma_go && ctrl.tx;
  assign dma_rx_req = dma_go && !ctrl.tx;
  assign irq        = iflag && ctrl.ie;

  always_comb begin
    if (ack_cyc_addr)      sda_ack = !ctrl.en;
    else if (ack_cyc_data) sda_ack = ctrl.noack;
    else                   sda_ack = 1'b1;
  end

  p_slave_no_dma_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.master |-> !(dma_tx_req || dma_rx_req));
  p_addr_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_cyc_addr && ctrl.en) |-> !sda_ack);
endmodule

// File: rtl/i2c_ctrl_status.sv
module i2c_ctrl_status
  import i2c_cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       bus_busy,
  input  logic       addr_phase,
  input  logic       ev_xfer_start,
  input  logic       ev_xfer_done,
  input  logic       ack_in,
  input  logic       ev_addr_match,
  input  logic       addr_rw,
  input  logic       ev_arb_lost,
  input  logic       ev_data_access,
  input  logic       ack_cyc_addr,
  input  logic       ack_cyc_data,
  output logic       sda_ack,
  output logic       rsta_pulse,
  output logic       irq,
  output logic       dma_tx_req,
  output logic       dma_rx_req
);
  ctrl_t ctrl, wr_fields;
  stat_t st;
  logic  wr_ctrl, wr_stat, rsta_loss, pending;
  logic [REG_W-1:0] ctrl_view, stat_view;

  assign wr_ctrl = reg_we && !reg_sel;
  assign wr_stat = reg_we && reg_sel;

  assign wr_fields = '{en: reg_wdata[C_EN], ie: reg_wdata[C_IE], master: reg_wdata[C_MST],
                       tx: reg_wdata[C_TX], noack: reg_wdata[C_NOACK],
                       spare: reg_wdata[C_SPARE], dmaen: reg_wdata[C_DMA]};

  i2c_cs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_fields(wr_fields),
    .wr_rsta(reg_wdata[C_RSTA]), .busy_q(st.busy), .ctrl(ctrl),
    .rsta_pulse(rsta_pulse), .rsta_loss(rsta_loss)
  );

  i2c_cs_status u_stat (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .ev_xfer_start(ev_xfer_start),
    .ev_xfer_done(ev_xfer_done), .ack_in(ack_in), .ev_addr_match(ev_addr_match),
    .addr_rw(addr_rw), .ev_arb_lost(ev_arb_lost), .ev_data_access(ev_data_access),
    .rsta_loss(rsta_loss), .dma_mode(ctrl.dmaen && ctrl.master),
    .clr_if(wr_stat && reg_wdata[S_IF]), .clr_al(wr_stat && reg_wdata[S_AL]),
    .st(st), .pending(pending)
  );

  i2c_cs_out u_out (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .iflag(st.iflag), .pending(pending),
    .ack_cyc_addr(ack_cyc_addr), .ack_cyc_data(ack_cyc_data), .sda_ack(sda_ack),
    .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[C_EN]    = ctrl.en;
    ctrl_view[C_IE]    = ctrl.ie;
    ctrl_view[C_MST]   = ctrl.master;
    ctrl_view[C_TX]    = ctrl.tx || addr_phase;
    ctrl_view[C_NOACK] = ctrl.noack;
    ctrl_view[C_SPARE] = ctrl.spare;
    ctrl_view[C_DMA]   = ctrl.dmaen;
    stat_view          = '0;
    stat_view[S_TCF]   = st.tcf;
    stat_view[S_AAS]   = st.aas;
    stat_view[S_BUSY]  = st.busy;
    stat_view[S_AL]    = st.al;
    stat_view[S_SRW]   = st.srw;
    stat_view[S_IF]    = st.iflag;
    stat_view[S_RXAK]  = st.rxak;
  end

  assign reg_rdata = reg_sel ? stat_view : ctrl_view;

  // R9: interrupt line tracks flag and enable
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st.iflag && ctrl.ie));
endmodule

// File: tb/i2c_ctrl_status_test.sv
module i2c_ctrl_status_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic bus_busy = 0, addr_phase = 0, ev_xfer_start = 0, ev_xfer_done = 0, ack_in = 0;
  logic ev_addr_match = 0, addr_rw = 0, ev_arb_lost = 0, ev_data_access = 0;
  logic ack_cyc_addr = 0, ack_cyc_data = 0;
  logic sda_ack, rsta_pulse, irq, dma_tx_req, dma_rx_req;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_ctrl_status uut (.*);

  // behavioural model state
  bit m_en, m_ie, m_ms, m_tx, m_na, m_sp, m_dm;
  bit m_tcf = 1, m_aas, m_busy, m_al, m_srw, m_if, m_rxak, m_pend, m_rsta;

  always @(posedge clk) begin
    bit loss, ok, clr_if, clr_al;
    if (!rst_n) begin
      {m_en, m_ie, m_ms, m_tx, m_na, m_sp, m_dm} = 0;
      {m_aas, m_busy, m_al, m_srw, m_if, m_rxak, m_pend, m_rsta} = 0;
      m_tcf = 1;
    end else begin
      ok     = reg_we && !reg_sel && reg_wdata[2] && m_busy && m_ms;
      loss   = reg_we && !reg_sel && reg_wdata[2] && m_busy && !m_ms;
      clr_if = reg_we && reg_sel && reg_wdata[6];
      clr_al = reg_we && reg_sel && reg_wdata[3];
      if (ev_xfer_done || ev_addr_match || ev_arb_lost || loss) begin
        if (ev_addr_match || ev_arb_lost || loss || !(m_dm && m_ms)) m_if = 1;
        else if (clr_if) m_if = 0;
      end else if (clr_if) m_if = 0;
      if (ev_arb_lost || loss) m_al = 1; else if (clr_al) m_al = 0;
      if (ev_xfer_done) begin m_tcf = 1; m_rxak = ack_in; end
      else if (ev_xfer_start) m_tcf = 0;
      if (ev_addr_match) begin m_aas = 1; m_srw = addr_rw; end
      else if (m_busy && !bus_busy) m_aas = 0;
      if (ev_xfer_done) m_pend = 1; else if (ev_data_access) m_pend = 0;
      m_busy = bus_busy;
      m_rsta = ok;
      if (reg_we && !reg_sel)
        {m_en, m_ie, m_ms, m_tx, m_na, m_sp, m_dm} =
          {reg_wdata[7], reg_wdata[6], reg_wdata[5], reg_wdata[4], reg_wdata[3], reg_wdata[1], reg_wdata[0]};
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every output with the model (called away from the clock edge)
  task automatic compare();
    logic [7:0] ev;
    logic ea;
    if (reg_sel) ev = {m_rxak, m_if, m_srw, 1'b0, m_al, m_busy, m_aas, m_tcf}; // R5 R6 R7 R12
    else ev = {m_en, m_ie, m_ms, m_tx | addr_phase, m_na, 1'b0, m_sp, m_dm};   // R3 R11 R12
    chk(reg_sel ? "R7 status read" : "R11 control read", reg_rdata, ev);
    ea = ack_cyc_addr ? !m_en : (ack_cyc_data ? m_na : 1'b1);
    chk("R2 sda_ack", {7'd0, sda_ack}, {7'd0, ea});
    chk("R3 rsta_pulse", {7'd0, rsta_pulse}, {7'd0, m_rsta});
    chk("R9 irq", {7'd0, irq}, {7'd0, m_if & m_ie});
    chk("R10 dma_tx", {7'd0, dma_tx_req}, {7'd0, m_en & m_dm & m_ms & m_pend & m_tx});
    chk("R10 dma_rx", {7'd0, dma_rx_req}, {7'd0, m_en & m_dm & m_ms & m_pend & !m_tx});
  endtask

  task automatic clear_in();
    reg_we = 0; ev_xfer_start = 0; ev_xfer_done = 0; ev_addr_match = 0;
    ev_arb_lost = 0; ev_data_access = 0;
  endtask

  // inputs are already set after a falling edge; check, then wait one cycle
  task automatic tick();
    #1 compare();
    @(negedge clk);
    clear_in();
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d; tick();
  endtask

  task automatic peek(bit sel, logic [7:0] exp, string tag);
    reg_sel = sel; #1 chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset view
    peek(1, 8'h01, "R1 status reset");
    peek(0, 8'h00, "R1 control reset");
    rst_n = 1;
    @(negedge clk);
    // R3 legal repeat start: master on busy bus
    wr(0, 8'hE0);             // en, ie, master
    bus_busy = 1; tick();
    wr(0, 8'hE4);
    #1 chk("R3 pulse", {7'd0, rsta_pulse}, 8'd1);
    tick();
    #1 chk("R3 single", {7'd0, rsta_pulse}, 8'd0);
    peek(0, 8'hE0, "R3 reads zero");
    // R4 repeat start while another master holds bus
    wr(0, 8'hC0); wr(0, 8'hC4);
    peek(1, 8'h4D, "R4 al and iflag");
    #1 chk("R4 no pulse", {7'd0, rsta_pulse}, 8'd0);
    // R7 w1c with simultaneous set of arb lost
    reg_sel = 1; ev_arb_lost = 1; wr(1, 8'hFF);
    peek(1, 8'h4D, "R7 set beats clear");
    wr(1, 8'h48);
    peek(1, 8'h05, "R7 cleared");
    // R5 transfer start/done
    ev_xfer_start = 1; tick();
    peek(1, 8'h04, "R5 tcf cleared");
    ev_xfer_done = 1; ack_in = 1; tick();
    peek(1, 8'hC5, "R5 done rxak");
    // R6 address match and bus falling
    wr(1, 8'h40); ev_addr_match = 1; addr_rw = 1; tick();
    peek(1, 8'hE7, "R6 aas srw");
    bus_busy = 0; tick(); tick();
    peek(1, 8'hE1, "R6 aas cleared");
    // R8 R10 DMA master transmit
    wr(1, 8'h40); wr(0, 8'hF1); bus_busy = 1; ev_xfer_done = 1; tick();
    peek(1, 8'hA5, "R8 masked in dma");
    #1 chk("R10 tx req", {7'd0, dma_tx_req}, 8'd1);
    ev_data_access = 1; tick();
    #1 chk("R10 req drops", {7'd0, dma_tx_req}, 8'd0);
    wr(0, 8'hE1); ev_xfer_done = 1; tick();
    #1 chk("R10 rx req", {7'd0, dma_rx_req}, 8'd1);
    ev_arb_lost = 1; tick();
    #1 chk("R8 arb irq in dma", {7'd0, irq}, 8'd1);
    wr(0, 8'hC1);
    #1 chk("R10 slave no dma", {7'd0, dma_rx_req}, 8'd0);
    // R2 acknowledge levels
    wr(0, 8'h88); ack_cyc_addr = 1;
    #1 chk("R2 addr ack with noack", {7'd0, sda_ack}, 8'd0);
    ack_cyc_addr = 0; ack_cyc_data = 1;
    #1 chk("R2 data nak", {7'd0, sda_ack}, 8'd1);
    wr(0, 8'h00); ack_cyc_data = 0; ack_cyc_addr = 1;
    #1 chk("R2 disabled addr", {7'd0, sda_ack}, 8'd1);
    ack_cyc_addr = 0;
    // R11 R12 readback
    wr(0, 8'h82); addr_phase = 1;
    peek(0, 8'h92, "R11 tx in address");
    addr_phase = 0; peek(0, 8'h82, "R12 spare stored");
    // random cycles compared against the model each clock
    for (int i = 0; i < 3000; i++) begin
      reg_we = ($urandom_range(0, 5) == 0); reg_sel = $urandom_range(0, 1);
      reg_wdata = 8'($urandom);
      bus_busy = ($urandom_range(0, 3) != 0); addr_phase = $urandom_range(0, 1);
      ev_xfer_start = ($urandom_range(0, 4) == 0); ev_xfer_done = ($urandom_range(0, 4) == 0);
      ack_in = $urandom_range(0, 1); ev_addr_match = ($urandom_range(0, 7) == 0);
      addr_rw = $urandom_range(0, 1); ev_arb_lost = ($urandom_range(0, 9) == 0);
      ev_data_access = ($urandom_range(0, 3) == 0);
      ack_cyc_addr = $urandom_range(0, 1); ack_cyc_data = $urandom_range(0, 1);
      tick();
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule